// File: doc/BRIEF.md
# Two-Mode Subtract-and-Branch Core

This block is a very small processor core whose whole instruction set is one three-word instruction. Each instruction names two data addresses, a source and a destination, and a jump word. The core reads both data words, subtracts the source from the destination, stores the difference back at the destination, and then either jumps or falls through to the next instruction. The sign of the jump word picks one of two modes. A positive jump word selects plain subtraction, and the jump is taken when the difference is zero or negative. A negative jump word selects reversed subtraction. Both operands are bit-reversed before the subtract and the difference is reversed again afterwards. The jump is then taken when the stored result is zero or odd. A program can therefore shift right and test the low bit with no shifter in the core. A zero jump word stops the core.

The core has a single memory port. It drives one address, a read strobe, a write strobe and one write word. The memory returns data one cycle after a read. That data is three words wide and holds the word at the address in the low lane, followed by the next two words. The instruction fetch uses all three lanes. Operand reads use only the low lane. After reset the core waits in IDLE for a start pulse. Each instruction then moves through FETCH (issue the PC), DECODE (latch the instruction, issue the source address, or go to HALT on a zero jump word), LOADB (latch the source value, issue the destination address), and EXEC (subtract, write, update the PC, back to FETCH). HALT is terminal until reset.

Top module: `revsub_core`

## Requirements
- R1: While reset is high and afterwards until start is seen in IDLE, halted is 0 and neither mem_re nor mem_we is asserted.
- R2: An instruction is the three words at PC, PC+1 and PC+2 (source address, destination address, jump word), and an untaken jump continues at PC+3. Execution begins at address 0.
- R3: With a positive jump word, mem[dst] becomes mem[dst] − mem[src], modulo 2^W.
- R4: With a negative jump word, mem[dst] becomes rev(rev(mem[dst]) − rev(mem[src])), where rev mirrors bit i to bit W−1−i. With src holding 0 this leaves dst unchanged, and two such steps on a copy give a logical right shift by one.
- R5: With a positive jump word, the jump is taken exactly when the stored result is zero or has bit W−1 set.
- R6: With a negative jump word, the jump is taken exactly when the stored result is zero or has bit 0 set.
- R7: A jump word of zero performs no subtraction and no write. It asserts halted, which stays high, and no read or write strobe follows.
- R8: Every executed instruction takes exactly 4 cycles. A halting instruction raises halted 2 cycles after its fetch is issued.
- R9: A taken jump goes to the magnitude of the jump word: C when C is positive, −C when C is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins execution when the core is idle |
| halted | output | 1 | High once a zero jump word has been decoded |
| mem_addr | output | AW | Word address for a read or a write |
| mem_re | output | 1 | Read strobe; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | W | Word to write |
| mem_rdata | input | 3*W | Read data: lane 0 = word at address, lanes 1 and 2 = next two words |

## Verification
The bench runs short programs over a sweep of values and derives each expected word arithmetically: a sum, a doubling, a reversed difference and a logical right shift. The values include zero, one, the sign-bit-only word, all ones and the largest positive word, because these sit on the branch boundaries. A core that tested the sign bit in the reversed mode, or the low bit in the plain mode, would jump the wrong way on odd positive or even negative values. That shows up as a wrong flag word and a wrong cycle count. The halt instruction names operands whose change would be visible, so a core that still subtracted before stopping would leave a doubly changed word. Any strobe after halted is counted as a failure.

// File: rtl/revsub_pkg.sv
package revsub_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_LOADB,
        ST_EXEC,
        ST_HALT
    } core_state_t;

    localparam int FETCH_LANES = 3;
endpackage

// File: rtl/revsub_flip.sv
module revsub_flip #(
    parameter int W = 32
) (
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign q_o[i] = d_i[W-1-i];
    end
endmodule

// File: rtl/revsub_alu.sv
module revsub_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] dst_val_i,
    input  logic [W-1:0] src_val_i,
    input  logic         rev_mode_i,
    output logic [W-1:0] result_o,
    output logic         take_o
);
    logic [W-1:0] dst_rev, src_rev, dst_sel, src_sel, diff, diff_rev;

    revsub_flip #(.W(W)) u_flip_dst (.d_i(dst_val_i), .q_o(dst_rev));
    revsub_flip #(.W(W)) u_flip_src (.d_i(src_val_i), .q_o(src_rev));
    revsub_flip #(.W(W)) u_flip_out (.d_i(diff),      .q_o(diff_rev));

    // Only muxes and wiring sit around the single shared subtractor.
    assign dst_sel  = rev_mode_i ? dst_rev : dst_val_i;
    assign src_sel  = rev_mode_i ? src_rev : src_val_i;
    assign diff     = dst_sel - src_sel;
    assign result_o = rev_mode_i ? diff_rev : diff;
    // The test always looks at the unreversed difference: its top bit is
    // the result's low bit in reversed mode.
    assign take_o   = (diff == '0) || diff[W-1];
endmodule

// File: rtl/revsub_core.sv
module revsub_core #(
    parameter int W  = 32,
    parameter int AW = 10
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  start,
    output logic                                  halted,
    output logic [AW-1:0]                         mem_addr,
    output logic                                  mem_re,
    output logic                                  mem_we,
    output logic [W-1:0]                          mem_wdata,
    input  logic [revsub_pkg::FETCH_LANES*W-1:0]  mem_rdata
);
    import revsub_pkg::*;

    localparam logic [AW-1:0] PC_STEP = AW'(FETCH_LANES);

    core_state_t   state, nstate;
    logic [AW-1:0] pc, dst_addr;
    logic [W-1:0]  jump_word, src_val, jump_abs, alu_result;
    logic          alu_take;
    logic [W-1:0]  lane0, lane1, lane2;
    logic          unused_bits;

    assign lane0 = mem_rdata[W-1:0];
    assign lane1 = mem_rdata[2*W-1:W];
    assign lane2 = mem_rdata[3*W-1:2*W];

    revsub_alu #(.W(W)) u_alu (
        .dst_val_i (lane0),
        .src_val_i (src_val),
        .rev_mode_i(jump_word[W-1]),
        .result_o  (alu_result),
        .take_o    (alu_take)
    );

    assign jump_abs    = jump_word[W-1] ? (~jump_word + 1'b1) : jump_word;
    assign unused_bits = ^{lane1[W-1:AW], jump_abs[W-1:AW]};

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   nstate = start ? ST_FETCH : ST_IDLE;
            ST_FETCH:  nstate = ST_DECODE;
            ST_DECODE: nstate = (lane2 == '0) ? ST_HALT : ST_LOADB;
            ST_LOADB:  nstate = ST_EXEC;
            ST_EXEC:   nstate = ST_FETCH;
            ST_HALT:   nstate = ST_HALT;
            default:   nstate = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        mem_addr  = pc;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = alu_result;
        unique case (state)
            ST_FETCH: begin
                mem_re   = 1'b1;
                mem_addr = pc;
            end
            ST_DECODE: begin
                mem_re   = (lane2 != '0);
                mem_addr = lane0[AW-1:0];
            end
            ST_LOADB: begin
                mem_re   = 1'b1;
                mem_addr = dst_addr;
            end
            ST_EXEC: begin
                mem_we   = 1'b1;
                mem_addr = dst_addr;
            end
            default: ;
        endcase
    end

    assign halted = (state == ST_HALT);

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            dst_addr  <= '0;
            jump_word <= '0;
            src_val   <= '0;
        end else begin
            unique case (state)
                ST_DECODE: begin
                    dst_addr  <= lane1[AW-1:0];
                    jump_word <= lane2;
                end
                ST_LOADB: src_val <= lane0;
                ST_EXEC:  pc <= alu_take ? jump_abs[AW-1:0] : pc + PC_STEP;
                default: ;
            endcase
        end
    end

    p_quiet_reset_r1: assert property (@(posedge clk)
        (state == ST_IDLE) |-> (!mem_re && !mem_we && !halted));
    p_fallthrough_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !alu_take) |=> (pc == $past(pc) + PC_STEP));
    p_sign_branch_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !jump_word[W-1] && alu_take)
            |-> (alu_result == '0 || alu_result[W-1]));
    p_odd_branch_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && jump_word[W-1] && alu_take)
            |-> (alu_result == '0 || alu_result[0]));
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_re && !mem_we));
    p_write_then_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (state == ST_FETCH && mem_re && !mem_we));
    p_jump_target_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && alu_take) |=> (pc == $past(jump_abs[AW-1:0])));
endmodule

// File: tb/revsub_core_bench.sv
module revsub_core_bench;
    localparam int W  = 32;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;
    localparam int XA = 200, YA = 201, ZA = 202, KA = 203, M1A = 204, FA = 205;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic halted, mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0] mem_wdata;
    logic [3*W-1:0] mem_rdata = '0;
    logic [W-1:0] mem [DEPTH];

    int checks = 0, errors = 0, strobes_in_halt = 0;

    always #2.5 clk = ~clk;

    revsub_core #(.W(W), .AW(AW)) u_revsub_core (
        .clk(clk), .rst(rst), .start(start), .halted(halted),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_re)
            mem_rdata <= {mem[mem_addr + AW'(2)], mem[mem_addr + AW'(1)], mem[mem_addr]};
        if (mem_we)
            mem[mem_addr] <= mem_wdata;
        if (halted && (mem_re || mem_we))
            strobes_in_halt <= strobes_in_halt + 1;
    end

    function automatic logic [W-1:0] rev(input logic [W-1:0] x);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = x[W-1-i];
        return r;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        mem[M1A] = '1;
    endtask

    task automatic put3(input int at, input int a, input int b, input int c);
        mem[at]     = W'(a);
        mem[at + 1] = W'(b);
        mem[at + 2] = W'(c);
    endtask

    // Runs the loaded program and returns edges from start until halted.
    task automatic run(output int cyc);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        strobes_in_halt = 0;
        start = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!halted && cyc < 2000) begin
            @(posedge clk); #1;
            if (!halted) cyc++;
        end
        if (!halted) begin
            errors++;
            $display("FAIL watchdog: core did not halt, actual=running expected=halted");
        end
        repeat (4) @(posedge clk);
        #1;
        check("R7 no strobe while halted", W'(strobes_in_halt), '0);
        check("R7 halted stays high", W'(halted), W'(1));
    endtask

    logic [W-1:0] vals [12];

    initial begin
        int cyc;
        logic [W-1:0] x, y, lcg;
        vals[0] = 0; vals[1] = 1; vals[2] = 2; vals[3] = 3;
        vals[4] = 32'h8000_0000; vals[5] = 32'h7fff_ffff; vals[6] = 32'hffff_ffff;
        vals[7] = 32'h4000_0000; vals[8] = 32'h8000_0001; vals[9] = 32'hffff_fffe;
        vals[10] = 32'h1234_5678; vals[11] = 32'hdead_beef;

        clear_mem();
        repeat (3) @(posedge clk);
        #1;
        check("R1 halted low in reset", W'(halted), '0);
        check("R1 no strobe in reset", W'(mem_re | mem_we), '0);
        @(negedge clk); rst = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        check("R1 idle without start: halted", W'(halted), '0);
        check("R1 idle without start: strobes", W'(mem_re | mem_we), '0);

        lcg = 32'h0bad_f00d;
        for (int i = 0; i < 24; i++) begin
            if (i < 12) begin
                x = vals[i];
                y = vals[(i * 5 + 3) % 12];
            end else begin
                lcg = lcg * 32'd1664525 + 32'd1013904223; x = lcg;
                lcg = lcg * 32'd1664525 + 32'd1013904223; y = lcg;
            end

            // R3, R7: one plain subtract; the halt names X,Y and must not repeat it.
            clear_mem(); mem[XA] = x; mem[YA] = y;
            put3(0, XA, YA, 3); put3(3, XA, YA, 0);
            run(cyc);
            check("R3 plain subtract", mem[YA], y - x);
            check("R8 one instr + halt cycles", W'(cyc), W'(6));

            // R4: reversed subtract.
            clear_mem(); mem[XA] = x; mem[YA] = y;
            put3(0, XA, YA, -3); put3(3, 0, 0, 0);
            run(cyc);
            check("R4 reversed subtract", mem[YA], rev(rev(y) - rev(x)));

            // R2, R3: add Y += X through a scratch cell.
            clear_mem(); mem[XA] = x; mem[YA] = y;
            put3(0, XA, ZA, 3); put3(3, ZA, YA, 6); put3(6, ZA, ZA, 9); put3(9, 0, 0, 0);
            run(cyc);
            check("R3 add result", mem[YA], x + y);
            check("R2 scratch cleared", mem[ZA], '0);
            check("R8 three instr + halt cycles", W'(cyc), W'(14));

            // R3: left shift by doubling.
            clear_mem(); mem[YA] = y;
            put3(0, YA, ZA, 3); put3(3, ZA, YA, 6); put3(6, ZA, ZA, 9); put3(9, 0, 0, 0);
            run(cyc);
            check("R3 left shift", mem[YA], y << 1);

            // R4: logical right shift via two reversed steps.
            clear_mem(); mem[XA] = x;
            put3(0, XA, ZA, -3); put3(3, ZA, XA, -6); put3(6, ZA, ZA, 9); put3(9, 0, 0, 0);
            run(cyc);
            check("R4 right shift", mem[XA], x >> 1);

            // R5, R9: plain branch on zero-or-negative; F counts the fall-through.
            clear_mem(); mem[YA] = y;
            put3(0, KA, YA, 9); put3(3, M1A, FA, 6); put3(6, 0, 0, 0); put3(9, 0, 0, 0);
            run(cyc);
            check("R5 sign branch flag", mem[FA], (y == 0 || y[W-1]) ? '0 : W'(1));
            check("R5 operand kept", mem[YA], y);
            check("R8 branch path cycles", W'(cyc), (y == 0 || y[W-1]) ? W'(6) : W'(10));

            // R6, R9: reversed branch on zero-or-odd with a negative jump word.
            clear_mem(); mem[YA] = y;
            put3(0, KA, YA, -9); put3(3, M1A, FA, 6); put3(6, 0, 0, 0); put3(9, 0, 0, 0);
            run(cyc);
            check("R6 odd branch flag", mem[FA], (y == 0 || y[0]) ? '0 : W'(1));
            check("R4 zero source keeps word", mem[YA], y);
            check("R9 odd branch cycles", W'(cyc), (y == 0 || y[0]) ? W'(6) : W'(10));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: bench timed out, actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule